// File: doc/BRIEF.md
# Stackless Tail-Recursion Function Header

This block sits between a caller and one hardware function body and runs calls to that body without a stack. The caller presents an argument and raises a call trigger. The header copies the argument onto the body-parameter output and then gives the body a one-cycle start pulse. The body works for as many cycles as it needs. It then pulses a ready strobe, with its result and a recursion-demand flag alongside.

The header captures the result and the flag together on that strobe, then acts on them. If the flag is clear, the captured value goes to the caller's result output and the caller's ready rises. If the flag is set, the value goes back onto the body-parameter output as the next argument and the body is started again. The caller sees nothing of this. A chain of tail calls therefore runs as a loop with no storage that grows with the call depth.

The caller uses a four-phase handshake. Its ready stays high for as long as it holds its trigger, and falls once the trigger drops. A new call is taken only when the header is idle.

Top module: `tail_call_header`

## Requirements
- R1: After a synchronous active-high reset, the caller-side ready, the start pulse, the body-parameter output and the caller-side result are all 0.
- R2: When the trigger is sampled high while the header is idle, the call argument appears on the body-parameter output in the next cycle. The start output is high during that same cycle.
- R3: The start output is never high in two consecutive cycles.
- R4: A ready strobe from the body with the recursion flag low raises the caller-side ready two cycles later. The captured result is then present on the caller-side result output.
- R5: A ready strobe with the recursion flag high places the captured result on the body-parameter output and pulses start two cycles later. The caller-side ready stays low.
- R6: The recursion flag and the result are sampled only in the cycle of the ready strobe. Their values in any other cycle have no effect on the outcome.
- R7: The caller-side ready stays high while the trigger stays high. It goes low in the cycle after the trigger is sampled low.
- R8: A held trigger or a changed call argument while the header is busy or finished starts nothing, and leaves the body-parameter output unchanged.
- R9: With the example body (68 returns 86; any other value above 12 returns 13; values from 2 to 12 recurse with the value minus two; 0 and 1 return themselves), each call returns that function's result. The number of body starts equals one plus the number of recursive steps (an argument of 7 gives 1 after four starts).
- R10: The parameter and result paths take their width from parameter `DATA_W`, which defaults to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| callTrig | input | 1 | Call request from the caller, held until callReady |
| callParam | input | DATA_W | Call argument |
| callReady | output | 1 | Call finished; held until callTrig drops |
| callResult | output | DATA_W | Final return value |
| bodyParam | output | DATA_W | Argument presented to the function body |
| bodyStart | output | 1 | One-cycle start pulse to the body |
| bodyReady | input | 1 | One-cycle completion strobe from the body |
| bodyResult | input | DATA_W | Body return value, valid with bodyReady |
| bodyRecurse | input | 1 | Recursion demand, valid with bodyReady |

## Verification
The assertions assume three things about the body and the caller. The body strobes ready only while the header is waiting for it, and only after the start it answers. The caller keeps its trigger high until ready rises. The bench meets both assumptions with a body model that answers each start pulse exactly once, after a random delay of one to four cycles, and with a caller task that holds the trigger through the whole call. Outside the ready strobe, the body model drives random values on the result and recursion inputs. Any dependence on those values shows up as a wrong final result or a wrong start count.

// File: rtl/tch_pkg.sv
package tch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_DECIDE = 3'd3,
    ST_DONE   = 3'd4
  } hdr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCall;    // capture caller argument into parameter register
    logic latchBody;   // capture body result and recursion flag
    logic loadFeed;    // feed captured result back as next parameter
    logic loadResult;  // publish captured result to caller
  } hdr_strobe_t;

endpackage

// File: rtl/tch_ctrl.sv
module tch_ctrl
  import tch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        callTrig,
  input  logic        bodyReady,
  input  logic        recFlag,
  output hdr_strobe_t strb,
  output logic        bodyStart,
  output logic        callReady
);

  hdr_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (callTrig) begin
          strb.loadCall = 1'b1;
          stateNext     = ST_START;
        end
      end
      ST_START: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (bodyReady) begin
          strb.latchBody = 1'b1;
          stateNext      = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (recFlag) begin
          strb.loadFeed = 1'b1;
          stateNext     = ST_START;
        end else begin
          strb.loadResult = 1'b1;
          stateNext       = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!callTrig) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign bodyStart = (state == ST_START);
  assign callReady = (state == ST_DONE);

  // R3: start is a single-cycle pulse
  a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
    bodyStart |=> !bodyStart);

  // R4: non-recursive return raises caller ready next
  a_r4_return_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && !recFlag) |=> callReady);

  // R5: recursive return restarts the body, caller ready stays low
  a_r5_restart_body: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && recFlag) |=> (bodyStart && !callReady));

  // R6: input assumption - body strobes only while awaited
  a_r6_ready_when_waiting: assert property (@(posedge clk) disable iff (rst)
    bodyReady |-> (state == ST_WAIT));

  // R7: four-phase hold and release
  a_r7_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (callReady && callTrig) |=> callReady);
  a_r7_ready_release: assert property (@(posedge clk) disable iff (rst)
    (callReady && !callTrig) |=> !callReady);

  // R8: no start while the caller still holds a finished call
  a_r8_no_restart_done: assert property (@(posedge clk) disable iff (rst)
    callReady |=> !bodyStart);

endmodule

// File: rtl/tch_dpath.sv
module tch_dpath
  import tch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  hdr_strobe_t       strb,
  input  logic [DATA_W-1:0] callParam,
  input  logic [DATA_W-1:0] bodyResult,
  input  logic              bodyRecurse,
  output logic [DATA_W-1:0] bodyParam,
  output logic [DATA_W-1:0] callResult,
  output logic              recFlag
);

  logic [DATA_W-1:0] paramReg, retLatch, resultReg;
  logic              recLatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      paramReg  <= '0;
      retLatch  <= '0;
      resultReg <= '0;
      recLatch  <= 1'b0;
    end else begin
      if (strb.loadCall)   paramReg  <= callParam;
      else if (strb.loadFeed) paramReg <= retLatch;
      if (strb.latchBody) begin
        retLatch <= bodyResult;
        recLatch <= bodyRecurse;
      end
      if (strb.loadResult) resultReg <= retLatch;
    end
  end

  assign bodyParam  = paramReg;
  assign callResult = resultReg;
  assign recFlag    = recLatch;

  // R2: caller argument reaches the body one cycle after capture
  a_r2_arg_capture: assert property (@(posedge clk) disable iff (rst)
    strb.loadCall |=> (bodyParam == $past(callParam)));

  // R5: fed-back parameter is the body result taken at the strobe
  a_r5_feed_value: assert property (@(posedge clk) disable iff (rst)
    strb.latchBody ##1 strb.loadFeed |=> (bodyParam == $past(bodyResult, 2)));

  // R6: recursion decision uses the flag seen at the strobe
  a_r6_flag_latched: assert property (@(posedge clk) disable iff (rst)
    strb.latchBody |=> (recFlag == $past(bodyRecurse)));

  // R8: parameter output frozen unless a load strobe fires
  a_r8_param_frozen: assert property (@(posedge clk) disable iff (rst)
    !(strb.loadCall || strb.loadFeed) |=> $stable(bodyParam));

endmodule

// File: rtl/tail_call_header.sv
module tail_call_header
  import tch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              callTrig,
  input  logic [DATA_W-1:0] callParam,
  output logic              callReady,
  output logic [DATA_W-1:0] callResult,
  output logic [DATA_W-1:0] bodyParam,
  output logic              bodyStart,
  input  logic              bodyReady,
  input  logic [DATA_W-1:0] bodyResult,
  input  logic              bodyRecurse
);

  hdr_strobe_t strb;
  logic        recFlag;

  tch_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .callTrig  (callTrig),
    .bodyReady (bodyReady),
    .recFlag   (recFlag),
    .strb      (strb),
    .bodyStart (bodyStart),
    .callReady (callReady)
  );

  tch_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .callParam   (callParam),
    .bodyResult  (bodyResult),
    .bodyRecurse (bodyRecurse),
    .bodyParam   (bodyParam),
    .callResult  (callResult),
    .recFlag     (recFlag)
  );

endmodule

// File: tb/tail_call_header_tb_top.sv
`timescale 1ns/1ps
module tail_call_header_tb_top;

  localparam int W = 8;   // R10: default width

  logic         clk = 1'b0;
  logic         rst;
  logic         callTrig;
  logic [W-1:0] callParam;
  logic         callReady;
  logic [W-1:0] callResult;
  logic [W-1:0] bodyParam;
  logic         bodyStart;
  logic         bodyReady;
  logic [W-1:0] bodyResult;
  logic         bodyRecurse;

  int nChecks = 0;
  int nFail   = 0;
  int startCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  tail_call_header dut_i (
    .clk(clk), .rst(rst),
    .callTrig(callTrig), .callParam(callParam),
    .callReady(callReady), .callResult(callResult),
    .bodyParam(bodyParam), .bodyStart(bodyStart),
    .bodyReady(bodyReady), .bodyResult(bodyResult), .bodyRecurse(bodyRecurse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one step of the example body
  function automatic void bodyStep(input int n, output int res, output bit rec);
    if (n == 68)     begin res = 86;    rec = 0; end
    else if (n > 12) begin res = 13;    rec = 0; end
    else if (n > 1)  begin res = n - 2; rec = 1; end
    else             begin res = n;     rec = 0; end
  endfunction

  // whole call: result, start count, last body argument
  function automatic void refCall(input int arg, output int res, output int starts, output int lastArg);
    int n = arg;
    bit rec;
    starts = 0;
    res = 0;
    lastArg = arg;
    forever begin
      starts++;
      lastArg = n;
      bodyStep(n, res, rec);
      if (!rec) break;
      n = res;
    end
  endfunction

  // body model: answers each start after 1..4 cycles, noise otherwise
  initial begin
    int pend = 0;
    int pendRes = 0;
    bit pendRec = 0;
    bit lastWasRec = 0;
    int lastRes = 0;
    bodyReady = 0; bodyResult = '0; bodyRecurse = 0;
    forever begin
      @(negedge clk);
      bodyReady = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          bodyReady   = 1;
          bodyResult  = W'(pendRes);
          bodyRecurse = pendRec;
          lastWasRec  = pendRec;
          lastRes     = pendRes;
        end
      end
      if (!bodyReady) begin
        bodyResult  = W'($urandom);   // R6: noise off the strobe
        bodyRecurse = 1'($urandom);
      end
      if (bodyStart) begin
        startCount++;
        if (lastWasRec)   // R5: fed-back argument
          check(int'(bodyParam) == lastRes, "R5", int'(bodyParam), lastRes);
        bodyStep(int'(bodyParam), pendRes, pendRec);
        pend = 1 + int'($urandom % 4);
      end
    end
  end

  task automatic doCall(input int arg);
    int expRes, expStarts, lastArg, cyc, startsSeen;
    bit seen;
    refCall(arg, expRes, expStarts, lastArg);
    @(negedge clk);
    startCount = 0;
    callParam = W'(arg);
    callTrig  = 1;
    @(negedge clk); #1;
    check(int'(bodyParam) == arg, "R2", int'(bodyParam), arg);
    check(bodyStart == 1'b1, "R2", int'(bodyStart), 1);
    seen = 0;
    for (cyc = 0; cyc < 400 && !seen; cyc++) begin
      @(negedge clk); #1;
      if (callReady) seen = 1;
    end
    check(seen, "R4", int'(seen), 1);
    check(int'(callResult) == expRes, "R9", int'(callResult), expRes);
    check(startCount == expStarts, "R9", startCount, expStarts);
    // held trigger with a new argument: nothing restarts (R8), ready holds (R7)
    startsSeen = startCount;
    callParam = W'(arg ^ 8'h5A);
    repeat (2) begin
      @(negedge clk); #1;
      check(callReady == 1'b1, "R7", int'(callReady), 1);
    end
    check(startCount == startsSeen, "R8", startCount, startsSeen);
    check(int'(bodyParam) == lastArg, "R8", int'(bodyParam), lastArg);
    callTrig = 0;
    @(negedge clk); #1;
    check(callReady == 1'b0, "R7", int'(callReady), 0);
    @(negedge clk); #1;
    check(bodyStart == 1'b0 && startCount == startsSeen, "R8", startCount, startsSeen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'd4242));
    rst = 1; callTrig = 0; callParam = '0;
    repeat (3) @(negedge clk);
    #1;
    check(callReady == 1'b0, "R1", int'(callReady), 0);
    check(bodyStart == 1'b0, "R1", int'(bodyStart), 0);
    check(int'(bodyParam) == 0, "R1", int'(bodyParam), 0);
    check(int'(callResult) == 0, "R1", int'(callResult), 0);
    @(negedge clk);
    rst = 0;
    // directed corners
    doCall(68);
    doCall(14);
    doCall(7);
    doCall(0);
    doCall(1);
    doCall(2);
    doCall(12);
    doCall(13);
    doCall(255);
    // random calls, biased toward recursive arguments
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 2) == 0) doCall(int'($urandom % 16));
      else                     doCall(int'($urandom % 256));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule